// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small processor core may stop its clocks and when it must start them again. The instruction decoder asks for a light sleep (idle) or a deep sleep (power-down) with a single-cycle request. The sequencer waits until the instruction ahead of the request has retired and the external bus has no cycle outstanding. It can also turn the request down, so that the core simply keeps running. Once it has entered a sleep state it drives registered clock enables: idle stops only the core clock, and power-down stops the peripheral clock as well.

While idle, the block watches a vector of interrupt sources. For each source it sees a request line, an enable flag, a priority level and a service type (core interrupt or peripheral data transfer). Only sources whose enable flag was set at the moment of entry can end the idle state, and the global interrupt enable has no say in that. The highest-priority waking source is picked. Depending on its type, its priority against the current core priority and the global enable, the sequencer does one of three things: it wakes the core with a vectoring indication, it wakes the core without vectoring, or it starts one data-transfer cycle and stays asleep. Power-down is left only through the asynchronous reset.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, cpu_clk_en and per_clk_en are 1 and resume, vector_go and xfer_start are 0.
- R2: After an entry request, cpu_clk_en stays 1 while prev_done is 0 or bus_busy is 1. It falls at the second clock edge after the request when the core is already drained, or at the first edge at which prev_done is 1 and bus_busy is 0.
- R3: If, at the point where the core is drained, rdy_en is 1 and rdy_seen is 0, the entry is refused: cpu_clk_en and per_clk_en stay 1 and no resume strobe is produced.
- R4: In idle, cpu_clk_en is 0 and per_clk_en is 1.
- R5: In power-down, both clock enables are 0, and no source request changes them. Only reset leaves this state.
- R6: A source can wake the idle core only if bit i of src_en was 1 at entry. Changing src_en after entry has no effect on waking, and glob_en does not gate the wake.
- R7: A waking source with src_xfer=0, a priority strictly above cpu_prio and glob_en=1 produces resume=1 and vector_go=1 for exactly one cycle, with sel_src equal to its index. cpu_clk_en is 1 in that same cycle.
- R8: A waking core-service source whose priority is not above cpu_prio, or that wakes while glob_en is 0, produces resume=1 with vector_go=0.
- R9: A waking source with src_xfer=1 that passes the priority and global-enable test produces a one-cycle xfer_start with sel_src equal to its index. There is no resume and cpu_clk_en stays 0. After xfer_done, the block returns to idle with cpu_clk_en still 0.
- R10: A waking transfer source that fails the priority or global-enable test produces resume=1, vector_go=0 and no xfer_start.
- R11: When several armed sources request at once, the source with the highest priority level wins, and the lowest index wins a tie.
- R12: When the block takes both an idle and a power-down request in the same cycle, power-down is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| idle_req | input | 1 | Validated idle entry request (pulse) |
| pdown_req | input | 1 | Validated power-down entry request (pulse) |
| prev_done | input | 1 | The preceding instruction has completed |
| bus_busy | input | 1 | An external bus cycle is outstanding |
| rdy_en | input | 1 | Ready handshake is enabled on the bus |
| rdy_seen | input | 1 | Ready was driven low during the last bus access |
| src_req | input | NSRC | Per-source request lines |
| src_en | input | NSRC | Per-source enable flags |
| src_xfer | input | NSRC | Per-source service type: 1 = data transfer, 0 = core interrupt |
| src_prio | input | NSRC*PRIO_W | Per-source priority; source i occupies bits i*PRIO_W upward |
| cpu_prio | input | PRIO_W | Current core priority level |
| glob_en | input | 1 | Global interrupt enable |
| xfer_done | input | 1 | Transfer engine has finished the started cycle |
| cpu_clk_en | output | 1 | Core clock enable (registered) |
| per_clk_en | output | 1 | Peripheral clock enable (registered) |
| resume | output | 1 | One-cycle strobe: the core restarts |
| vector_go | output | 1 | With resume: 1 = enter the service routine, 0 = continue with the next instruction |
| sel_src | output | $clog2(NSRC) | Index of the source chosen at the last decision |
| xfer_start | output | 1 | One-cycle strobe: start one data transfer |

## Verification
A wrong state in this block shows up on the clock enables within one or two edges. A sequencer stuck in the drain wait keeps cpu_clk_en high. Leaking out of power-down raises either enable while a source is requesting. A transfer cycle that fails to go back to idle brings cpu_clk_en up, or raises resume one edge after xfer_done. A wrong snapshot or a wrong arbitration choice appears in the same cycle as the wake, as a strobe that should not be there, a missing strobe, or the wrong sel_src or vector_go value. The directed scenarios hold each wake condition steady for several cycles, so that a spurious exit is caught as well as a late one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      ST_RUN        = 3'd0,
      ST_WAIT_DRAIN = 3'd1,
      ST_IDLE       = 3'd2,
      ST_XFER       = 3'd3,
      ST_PWRDN      = 3'd4,
      ST_WAKE       = 3'd5
   } lpm_state_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_RESUME = 2'd1,
      ACT_VECTOR = 2'd2,
      ACT_XFER   = 2'd3
   } lpm_action_e;
endpackage

// File: rtl/lpm_arbiter.sv
module lpm_arbiter #(
   parameter int NSRC   = 8,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]        cand,
   input  logic [NSRC*PRIO_W-1:0] prio_flat,
   output logic                   any,
   output logic [IDX_W-1:0]       win_idx,
   output logic [PRIO_W-1:0]      win_prio
);
   logic [PRIO_W-1:0] prio_a [NSRC];

   initial begin
      assert (NSRC >= 1 && NSRC <= 256) else $error("lpm_arbiter: NSRC out of range");
      assert (PRIO_W >= 1 && PRIO_W <= 8) else $error("lpm_arbiter: PRIO_W out of range");
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_unpack
      assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
   end

   // Strictly-greater compare on an ascending scan keeps the lowest index on a tie.
   always_comb begin
      any      = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (cand[i] && (!any || (prio_a[i] > win_prio))) begin
            any      = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = prio_a[i];
         end
      end
   end

   always_comb begin
      if (any) begin
         assert (cand[win_idx]) else $error("AST_GRANT_REQUESTING"); // R11
      end
   end
endmodule

// File: rtl/lpm_entry_gate.sv
module lpm_entry_gate (
   input  logic prev_done,
   input  logic bus_busy,
   input  logic rdy_en,
   input  logic rdy_seen,
   output logic drained,
   output logic refuse
);
   assign drained = prev_done & ~bus_busy;
   assign refuse  = rdy_en & ~rdy_seen;
endmodule

// File: rtl/lpm_service_check.sv
module lpm_service_check #(
   parameter int PRIO_W = 4
) (
   input  logic              any,
   input  logic              win_xfer,
   input  logic [PRIO_W-1:0] win_prio,
   input  logic [PRIO_W-1:0] cpu_prio,
   input  logic              glob_en,
   output lpm_pkg::lpm_action_e action
);
   import lpm_pkg::*;
   logic svc_ok;

   assign svc_ok = glob_en && (win_prio > cpu_prio);

   always_comb begin
      if (!any)                action = ACT_NONE;
      else if (!svc_ok)        action = ACT_RESUME;
      else if (win_xfer)       action = ACT_XFER;
      else                     action = ACT_VECTOR;
   end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
   parameter int NSRC   = 8,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   idle_req,
   input  logic                   pdown_req,
   input  logic                   prev_done,
   input  logic                   bus_busy,
   input  logic                   rdy_en,
   input  logic                   rdy_seen,
   input  logic [NSRC-1:0]        src_req,
   input  logic [NSRC-1:0]        src_en,
   input  logic [NSRC-1:0]        src_xfer,
   input  logic [NSRC*PRIO_W-1:0] src_prio,
   input  logic [PRIO_W-1:0]      cpu_prio,
   input  logic                   glob_en,
   input  logic                   xfer_done,
   output logic                   cpu_clk_en,
   output logic                   per_clk_en,
   output logic                   resume,
   output logic                   vector_go,
   output logic [IDX_W-1:0]       sel_src,
   output logic                   xfer_start
);
   import lpm_pkg::*;

   lpm_state_e        st, nxt;
   logic              deep_q, deep_n;
   logic [NSRC-1:0]   en_snap;
   logic [NSRC-1:0]   cand;
   logic              any;
   logic [IDX_W-1:0]  win_idx;
   logic [PRIO_W-1:0] win_prio;
   logic              drained, refuse;
   lpm_action_e       action;
   logic              in_idle, enter_ok;

   initial begin
      assert (IDX_W >= 1 && (1 << IDX_W) >= NSRC) else $error("lpm_sequencer: IDX_W too small");
   end

   lpm_entry_gate u_gate (
      .prev_done (prev_done),
      .bus_busy  (bus_busy),
      .rdy_en    (rdy_en),
      .rdy_seen  (rdy_seen),
      .drained   (drained),
      .refuse    (refuse)
   );

   assign in_idle = (st == ST_IDLE);
   assign cand    = in_idle ? (src_req & en_snap) : '0;

   lpm_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
      .cand      (cand),
      .prio_flat (src_prio),
      .any       (any),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   lpm_service_check #(.PRIO_W(PRIO_W)) u_svc (
      .any      (any),
      .win_xfer (src_xfer[win_idx]),
      .win_prio (win_prio),
      .cpu_prio (cpu_prio),
      .glob_en  (glob_en),
      .action   (action)
   );

   assign enter_ok = (st == ST_WAIT_DRAIN) && drained && !refuse;

   always_comb begin
      nxt    = st;
      deep_n = deep_q;
      unique case (st)
         ST_RUN: begin
            if (pdown_req) begin
               nxt = ST_WAIT_DRAIN; deep_n = 1'b1;
            end else if (idle_req) begin
               nxt = ST_WAIT_DRAIN; deep_n = 1'b0;
            end
         end
         ST_WAIT_DRAIN: begin
            if (drained) begin
               if (refuse)      nxt = ST_RUN;
               else if (deep_q) nxt = ST_PWRDN;
               else             nxt = ST_IDLE;
            end
         end
         ST_IDLE: begin
            if (action == ACT_XFER)      nxt = ST_XFER;
            else if (action != ACT_NONE) nxt = ST_WAKE;
         end
         ST_XFER:  if (xfer_done) nxt = ST_IDLE;
         ST_PWRDN: nxt = ST_PWRDN;
         ST_WAKE:  nxt = ST_RUN;
         default:  nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_RUN;
         deep_q     <= 1'b0;
         en_snap    <= '0;
         cpu_clk_en <= 1'b1;
         per_clk_en <= 1'b1;
         resume     <= 1'b0;
         vector_go  <= 1'b0;
         xfer_start <= 1'b0;
         sel_src    <= '0;
      end else begin
         st         <= nxt;
         deep_q     <= deep_n;
         cpu_clk_en <= (nxt == ST_RUN) || (nxt == ST_WAIT_DRAIN) || (nxt == ST_WAKE);
         per_clk_en <= (nxt != ST_PWRDN);
         resume     <= in_idle && ((action == ACT_RESUME) || (action == ACT_VECTOR));
         vector_go  <= in_idle && (action == ACT_VECTOR);
         xfer_start <= in_idle && (action == ACT_XFER);
         if (enter_ok) en_snap <= src_en;
         if (in_idle && any) sel_src <= win_idx;
      end
   end

   AST_WAIT_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_DRAIN && !drained) |=> cpu_clk_en); // R2
   AST_ENTRY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_clk_en) |-> $past(drained)); // R2
   AST_REFUSE_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT_DRAIN && drained && refuse) |=> (cpu_clk_en && per_clk_en && !resume)); // R3
   AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (!cpu_clk_en && per_clk_en)); // R4
   AST_PDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PWRDN) |=> (st == ST_PWRDN && !cpu_clk_en && !per_clk_en)); // R5
   AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume); // R7
   AST_VECTOR_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      vector_go |-> (resume && cpu_clk_en)); // R8
   AST_XFER_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (!resume && !cpu_clk_en)); // R9
   AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start); // R9
endmodule

// File: tb/lpm_sequencer_tb.sv
`timescale 1ns/1ps
module lpm_sequencer_tb;
   localparam int NSRC   = 8;
   localparam int PRIO_W = 4;
   localparam int IDX_W  = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic idle_req, pdown_req, prev_done, bus_busy, rdy_en, rdy_seen;
   logic [NSRC-1:0] src_req, src_en, src_xfer;
   logic [NSRC*PRIO_W-1:0] src_prio;
   logic [PRIO_W-1:0] cpu_prio;
   logic glob_en, xfer_done;
   logic cpu_clk_en, per_clk_en, resume, vector_go, xfer_start;
   logic [IDX_W-1:0] sel_src;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   lpm_sequencer #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pdown_req(pdown_req),
      .prev_done(prev_done), .bus_busy(bus_busy), .rdy_en(rdy_en), .rdy_seen(rdy_seen),
      .src_req(src_req), .src_en(src_en), .src_xfer(src_xfer), .src_prio(src_prio),
      .cpu_prio(cpu_prio), .glob_en(glob_en), .xfer_done(xfer_done),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .resume(resume),
      .vector_go(vector_go), .sel_src(sel_src), .xfer_start(xfer_start)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic set_prio(input int i, input int p);
      src_prio[i*PRIO_W +: PRIO_W] = PRIO_W'(p);
   endtask

   task automatic do_reset();
      idle_req = 0; pdown_req = 0; prev_done = 1; bus_busy = 0;
      rdy_en = 0; rdy_seen = 0; src_req = '0; src_en = '0; src_xfer = '0;
      src_prio = '0; cpu_prio = '0; glob_en = 1; xfer_done = 0;
      rst_n = 0;
      step(2);
      rst_n = 1;
      step(1);
   endtask

   task automatic enter_idle();
      idle_req = 1; step(1);
      idle_req = 0; step(1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "cpu_clk_en", cpu_clk_en, 1);
      chk("R1", "per_clk_en", per_clk_en, 1);
      chk("R1", "resume", resume, 0);
      chk("R1", "vector_go", vector_go, 0);
      chk("R1", "xfer_start", xfer_start, 0);
   endtask

   task automatic t_drain();
      do_reset();
      prev_done = 0;
      idle_req = 1; step(1); idle_req = 0;
      step(2);
      chk("R2", "cpu_clk_en while instr pending", cpu_clk_en, 1);
      prev_done = 1; bus_busy = 1; step(2);
      chk("R2", "cpu_clk_en while bus busy", cpu_clk_en, 1);
      bus_busy = 0; step(1);
      chk("R2", "cpu_clk_en after drain", cpu_clk_en, 0);
      chk("R4", "per_clk_en in idle", per_clk_en, 1);
      step(3);
      chk("R4", "cpu_clk_en idle held", cpu_clk_en, 0);
   endtask

   task automatic t_refuse();
      do_reset();
      rdy_en = 1; rdy_seen = 0;
      enter_idle();
      chk("R3", "cpu_clk_en refused", cpu_clk_en, 1);
      chk("R3", "resume refused", resume, 0);
      step(2);
      chk("R3", "cpu_clk_en later", cpu_clk_en, 1);
      rdy_seen = 1;
      enter_idle();
      chk("R3", "cpu_clk_en accepted with ready seen", cpu_clk_en, 0);
   endtask

   task automatic t_pdown();
      do_reset();
      src_en = 8'hFF; set_prio(0, 9);
      idle_req = 1; pdown_req = 1; step(1);
      idle_req = 0; pdown_req = 0; step(1);
      chk("R12", "per_clk_en pdown wins", per_clk_en, 0);
      chk("R5", "cpu_clk_en pdown", cpu_clk_en, 0);
      src_req = 8'hFF; step(4);
      chk("R5", "cpu_clk_en with requests", cpu_clk_en, 0);
      chk("R5", "per_clk_en with requests", per_clk_en, 0);
      chk("R5", "resume with requests", resume, 0);
      rst_n = 0; #1;
      chk("R5", "cpu_clk_en after reset", cpu_clk_en, 1);
      chk("R5", "per_clk_en after reset", per_clk_en, 1);
   endtask

   task automatic t_wake_vector();
      do_reset();
      src_en[2] = 1; set_prio(2, 5); cpu_prio = 3; glob_en = 1;
      enter_idle();
      src_req[2] = 1; step(1);
      chk("R7", "resume", resume, 1);
      chk("R7", "vector_go", vector_go, 1);
      chk("R7", "sel_src", sel_src, 2);
      chk("R7", "cpu_clk_en", cpu_clk_en, 1);
      src_req = '0; step(1);
      chk("R7", "resume one cycle", resume, 0);
   endtask

   task automatic t_wake_novector();
      do_reset();
      src_en[6] = 1; set_prio(6, 3); cpu_prio = 3;
      enter_idle();
      src_req[6] = 1; step(1);
      chk("R8", "resume low prio", resume, 1);
      chk("R8", "vector_go low prio", vector_go, 0);
      do_reset();
      src_en[6] = 1; set_prio(6, 9); cpu_prio = 1; glob_en = 0;
      enter_idle();
      src_req[6] = 1; step(1);
      chk("R6", "wake with glob_en=0", resume, 1);
      chk("R8", "vector_go glob off", vector_go, 0);
   endtask

   task automatic t_snapshot();
      do_reset();
      src_en[1] = 1; glob_en = 0;
      enter_idle();
      src_en[4] = 1; src_en[1] = 0; src_req[4] = 1; step(3);
      chk("R6", "late-enabled source ignored cpu_clk_en", cpu_clk_en, 0);
      chk("R6", "late-enabled source ignored resume", resume, 0);
      src_req[4] = 0; src_req[1] = 1; step(1);
      chk("R6", "armed source wakes", resume, 1);
      chk("R6", "armed source index", sel_src, 1);
   endtask

   task automatic t_xfer();
      do_reset();
      src_en[5] = 1; src_en[0] = 1; src_xfer[5] = 1; set_prio(5, 7); cpu_prio = 2;
      enter_idle();
      src_req[5] = 1; step(1);
      chk("R9", "xfer_start", xfer_start, 1);
      chk("R9", "sel_src", sel_src, 5);
      chk("R9", "resume", resume, 0);
      chk("R9", "cpu_clk_en", cpu_clk_en, 0);
      src_req = '0; step(1);
      chk("R9", "xfer_start one cycle", xfer_start, 0);
      step(2);
      xfer_done = 1; step(1); xfer_done = 0;
      step(2);
      chk("R9", "back to idle cpu_clk_en", cpu_clk_en, 0);
      chk("R9", "back to idle resume", resume, 0);
      src_req[0] = 1; step(1);
      chk("R9", "wake after transfer", resume, 1);
   endtask

   task automatic t_xfer_fail();
      do_reset();
      src_en[3] = 1; src_xfer[3] = 1; set_prio(3, 7); cpu_prio = 2; glob_en = 0;
      enter_idle();
      src_req[3] = 1; step(1);
      chk("R10", "resume", resume, 1);
      chk("R10", "vector_go", vector_go, 0);
      chk("R10", "xfer_start", xfer_start, 0);
      chk("R10", "cpu_clk_en", cpu_clk_en, 1);
   endtask

   task automatic t_arb();
      do_reset();
      src_en = 8'b0100_1010;
      set_prio(1, 4); set_prio(3, 6); set_prio(6, 6);
      enter_idle();
      src_req = 8'b0100_1010; step(1);
      chk("R11", "highest prio, lowest index on tie", sel_src, 3);
      chk("R11", "vector_go", vector_go, 1);
      do_reset();
      src_en = 8'b1000_0100;
      set_prio(2, 1); set_prio(7, 12);
      enter_idle();
      src_req = 8'b1000_0100; step(1);
      chk("R11", "higher index higher prio", sel_src, 7);
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_drain();
      t_refuse();
      t_pdown();
      t_wake_vector();
      t_wake_novector();
      t_snapshot();
      t_xfer();
      t_xfer_fail();
      t_arb();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule